// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Hybrid PWM Generator

This block produces the four gate-drive signals of a phase-shifted full-bridge converter from an 11-bit duty command while switching at only 1/32 of the system clock (a 32 MHz clock gives a 1 MHz switching period). A plain counter-comparator scheme would need a clock of 2^11 times the switching frequency to reach that resolution. Here a 5-bit free-running period counter sets the coarse timing. A first-order error-feedback sigma-delta stage spreads the 6 low-order duty bits over successive periods by adding one count to the comparator threshold in selected periods. The average phase shift therefore keeps the full 11-bit resolution.

Each bridge leg is a complementary pair with a fixed dead time. The leading leg (outputs A and B) is fixed to the counter. The lagging leg (outputs C and D) is delayed by the dithered threshold, and that delay sets the effective duty. A new command is taken with a one-clock valid strobe. It is held and only applied at the next counter wrap, so each switching period is built from a single threshold.

Top module: `hsd_pwm_bridge`

## Requirements
- R1: While `rst_n` is low, all four switch outputs are low. After release, the counter restarts from zero and `sw_a` first rises on the third clock edge.
- R2: The switching period is 32 clocks. `sw_a` rises once every 32 clocks and stays high for 14 clocks (half period minus the 2-clock dead time).
- R3: `sw_b` rises 16 clocks after `sw_a` rises (180 degrees apart). `sw_a` and `sw_b` are never high together, and both are low for 2 clocks after `sw_a` falls.
- R4: `sw_c` stays high for 14 clocks. With a constant shift, `sw_d` rises 16 clocks after `sw_c`. `sw_c` and `sw_d` are never high together.
- R5: In each period, `sw_c` rises exactly S clocks after `sw_a`, where S is that period's shift. The coarse part of S is duty bits [10:6].
- R6: Duty bits [5:0] are added once per period to a 6-bit accumulator. The carry out adds one to that period's shift, so every shift is coarse or coarse+1. Over any 64 consecutive periods the shifts add up to 64*coarse + bits[5:0].
- R7: A duty command of zero gives a shift of zero: `sw_c` rises on the same clock as `sw_a`.
- R8: The shift saturates at 15, just below half a period. A coarse value plus carry above 15 gives 15.
- R9: A command taken with `duty_valid` mid-period leaves the current period unchanged. It takes effect from the period that starts after the next counter wrap.
- R10: Without `duty_valid`, changes on `duty_cmd` are ignored and the last accepted command stays in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_valid | input | 1 | One-clock strobe accepting `duty_cmd` |
| duty_cmd | input | 11 | Duty command, high 5 bits coarse, low 6 bits dithered |
| sw_a | output | 1 | Leading leg, upper switch |
| sw_b | output | 1 | Leading leg, lower switch |
| sw_c | output | 1 | Lagging leg, upper switch |
| sw_d | output | 1 | Lagging leg, lower switch |

## Verification
The outputs are registered one clock after the counter, so `sw_a` rises three edges after reset release, and every later measurement is taken relative to a `sw_a` rising edge rather than to absolute cycle numbers. A command is accepted on the next edge but only reaches the outputs in the period after the next wrap. The bench therefore waits more than two periods after each command before it checks the shift, except in the latch test, which injects a command right after `sw_a` rises and expects the old shift in that period and the new one in the next. Dithered commands are judged over 64 consecutive periods, where the shift sum is exact whatever the accumulator's starting state.

// File: rtl/hsd_pwm_pkg.sv
package hsd_pwm_pkg;

   // Role of a bridge leg: the leading leg is fixed to the counter,
   // the lagging leg is delayed by the dithered threshold.
   typedef enum logic [0:0] {
      LEG_LEAD = 1'b0,
      LEG_LAG  = 1'b1
   } leg_role_e;

   // Largest phase shift that keeps the lagging leg inside one period.
   function automatic int shift_limit(input int cnt_w);
      return (2 ** (cnt_w - 1)) - 1;
   endfunction

endpackage

// File: rtl/hsd_period_counter.sv
module hsd_period_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] TERM = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign cnt  = cnt_q;
   assign wrap = (cnt_q == TERM);

   // R2: the period restarts right after the terminal count
   p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0));

   // R2: the counter advances by one every clock between wraps
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/hsd_duty_dither.sv
module hsd_duty_dither #(
   parameter int CNT_W     = 5,
   parameter int DUTY_W    = 11,
   parameter int MAX_SHIFT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wrap,
   input  logic              cmd_valid,
   input  logic [DUTY_W-1:0] cmd_duty,
   output logic [CNT_W-1:0]  shift
);

   localparam int            FRAC_W = DUTY_W - CNT_W;
   localparam logic [CNT_W:0] CAP   = (CNT_W + 1)'(MAX_SHIFT);

   logic [DUTY_W-1:0] pend_q;
   logic [DUTY_W-1:0] eff;
   logic [CNT_W-1:0]  coarse;
   logic              carry;
   logic [CNT_W:0]    raw;
   logic [CNT_W-1:0]  capped;
   logic [CNT_W-1:0]  shift_q;

   // A strobe on the wrap edge itself is applied to the coming period.
   assign eff    = cmd_valid ? cmd_duty : pend_q;
   assign coarse = eff[DUTY_W-1 -: CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= '0;
      else if (cmd_valid) pend_q <= cmd_duty;
   end

   generate
      if (FRAC_W > 0) begin : g_dither
         logic [FRAC_W-1:0] acc_q;
         logic [FRAC_W:0]   acc_sum;

         assign acc_sum = {1'b0, acc_q} + {1'b0, eff[FRAC_W-1:0]};
         assign carry   = acc_sum[FRAC_W];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    acc_q <= '0;
            else if (wrap) acc_q <= acc_sum[FRAC_W-1:0];
         end
      end else begin : g_plain
         assign carry = 1'b0;
      end
   endgenerate

   assign raw    = {1'b0, coarse} + {{CNT_W{1'b0}}, carry};
   assign capped = (raw > CAP) ? CAP[CNT_W-1:0] : raw[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shift_q <= '0;
      else if (wrap) shift_q <= capped;
   end

   assign shift = shift_q;

   // R8: the shift never leaves the half period
   p_shift_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, shift_q} <= CAP));

   // R9: the threshold is constant inside a period
   p_hold_in_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(shift_q));

   // R10: the held command only moves on a strobe
   p_hold_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(pend_q));

   // R7: a zero command gives a zero shift in the next period
   p_zero_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && (eff == '0)) |=> (shift_q == '0));

endmodule

// File: rtl/hsd_leg_gen.sv
module hsd_leg_gen #(
   parameter int CNT_W = 5,
   parameter int DEAD  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] offset,
   output logic             hi,
   output logic             lo
);

   localparam int               HALF   = 2 ** (CNT_W - 1);
   localparam logic [CNT_W-1:0] DEAD_V = CNT_W'(DEAD);
   localparam logic [CNT_W-1:0] HALF_V = CNT_W'(HALF);
   localparam logic [CNT_W-1:0] LO_ON  = CNT_W'(HALF + DEAD);

   logic [CNT_W-1:0] phase;
   logic             hi_d, lo_d;
   logic             hi_q, lo_q;

   // Modulo subtraction puts the leg's own period origin at 'offset'.
   assign phase = cnt - offset;
   assign hi_d  = (phase >= DEAD_V) && (phase < HALF_V);
   assign lo_d  = (phase >= LO_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_d;
         lo_q <= lo_d;
      end
   end

   assign hi = hi_q;
   assign lo = lo_q;

   // R3/R4: the two switches of a leg never conduct together
   p_leg_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_q && lo_q));

   // R3: the lower switch is still off when the upper one releases
   p_dead_after_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hi_q) |-> !lo_q);

   // R4: the upper switch is still off when the lower one releases
   p_dead_after_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lo_q) |-> !hi_q);

endmodule

// File: rtl/hsd_pwm_bridge.sv
module hsd_pwm_bridge #(
   parameter int CNT_W  = 5,
   parameter int DUTY_W = 11,
   parameter int DEAD   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              duty_valid,
   input  logic [DUTY_W-1:0] duty_cmd,
   output logic              sw_a,
   output logic              sw_b,
   output logic              sw_c,
   output logic              sw_d
);

   import hsd_pwm_pkg::*;

   localparam int HALF      = 2 ** (CNT_W - 1);
   localparam int MAX_SHIFT = shift_limit(CNT_W);
   localparam int N_LEG     = 2;

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("CNT_W must be at least 3");
      end
      if (DUTY_W < CNT_W) begin : g_bad_duty
         $error("DUTY_W must not be below CNT_W");
      end
      if ((DEAD < 1) || (DEAD >= HALF / 2)) begin : g_bad_dead
         $error("DEAD must lie in 1 .. HALF/2-1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic [CNT_W-1:0] shift;
   logic [N_LEG-1:0] hi_v;
   logic [N_LEG-1:0] lo_v;

   hsd_period_counter #(.CNT_W(CNT_W)) i_counter (
      .clk  (clk),
      .rst_n(rst_n),
      .cnt  (cnt),
      .wrap (wrap)
   );

   hsd_duty_dither #(
      .CNT_W    (CNT_W),
      .DUTY_W   (DUTY_W),
      .MAX_SHIFT(MAX_SHIFT)
   ) i_dither (
      .clk      (clk),
      .rst_n    (rst_n),
      .wrap     (wrap),
      .cmd_valid(duty_valid),
      .cmd_duty (duty_cmd),
      .shift    (shift)
   );

   generate
      for (genvar g = 0; g < N_LEG; g++) begin : g_leg
         localparam leg_role_e ROLE = (g == 0) ? LEG_LEAD : LEG_LAG;
         logic [CNT_W-1:0] off;

         if (ROLE == LEG_LEAD) begin : g_lead
            assign off = '0;
         end else begin : g_lag
            assign off = shift;
         end

         hsd_leg_gen #(.CNT_W(CNT_W), .DEAD(DEAD)) i_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt),
            .offset(off),
            .hi    (hi_v[g]),
            .lo    (lo_v[g])
         );
      end
   endgenerate

   assign sw_a = hi_v[0];
   assign sw_b = lo_v[0];
   assign sw_c = hi_v[1];
   assign sw_d = lo_v[1];

   // R7: with no shift both upper switches turn on together
   p_zero_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sw_a) && (shift == '0)) |-> $rose(sw_c));

   // R5: with a shift the lagging leg is not yet on when the lead starts
   p_lag_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sw_a) && (shift != '0)) |-> !sw_c);

   // R4: lagging leg switches are exclusive at the ports
   p_cd_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_c && sw_d));

endmodule

// File: tb/test_hsd_pwm_bridge.sv
module test_hsd_pwm_bridge;

   typedef struct {
      int    lo;
      int    hi;
      int    sum;
      int    nper;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dvalid = 1'b0;
   logic [10:0] duty = '0;
   logic        sw_a, sw_b, sw_c, sw_d;
   logic        sa_p = 1'b0, sb_p = 1'b0, sc_p = 1'b0, sd_p = 1'b0;

   int   n_chk = 0, n_fail = 0;
   int   n_push = 0, n_done = 0;
   int   ovl_ab = 0, ovl_cd = 0;
   bit   finished = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;

   hsd_pwm_bridge i_hsd_pwm_bridge (
      .clk       (clk),
      .rst_n     (rst_n),
      .duty_valid(dvalid),
      .duty_cmd  (duty),
      .sw_a      (sw_a),
      .sw_b      (sw_b),
      .sw_c      (sw_c),
      .sw_d      (sw_d)
   );

   // values before the last edge, for edge detection at the falling edge
   always @(posedge clk) begin
      sa_p <= sw_a; sb_p <= sw_b; sc_p <= sw_c; sd_p <= sw_d;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (sw_a && sw_b) ovl_ab++;
         if (sw_c && sw_d) ovl_cd++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // Measures one period from a rising edge of sw_a; all results are
   // sample indices after that edge (-1 when the event was not seen).
   task automatic measure_period(input int inj, output int shift, output int aw,
                                 output int boff, output int cw, output int doff,
                                 output int gap);
      int s = -1, a = -1, b = -1, c = -1, d = -1, g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!(sw_a && !sa_p) && g < 200);
      if (inj >= 0) begin
         duty   = 11'(inj);
         dvalid = 1'b1;
      end
      if (sw_c && !sc_p) s = 0;
      for (int k = 1; k < 32; k++) begin
         @(negedge clk);
         if (k == 1) dvalid = 1'b0;
         if (!sw_a && sa_p && a < 0) a = k;
         if (sw_b && !sb_p && b < 0) b = k;
         if (sw_c && !sc_p && s < 0) s = k;
         if (!sw_c && sc_p && c < 0 && s >= 0) c = k - s;
         if (sw_d && !sd_p && d < 0 && s >= 0) d = k - s;
      end
      shift = s; aw = a; boff = b; cw = c; doff = d; gap = g;
   endtask

   task automatic apply(input int d);
      @(negedge clk);
      duty   = 11'(d);
      dvalid = 1'b1;
      @(negedge clk);
      dvalid = 1'b0;
      repeat (70) @(negedge clk);
   endtask

   // Expected shift range and sum taken from R5, R6 and R8.
   task automatic push_item(input int d, input int nper, input string tag);
      exp_t it;
      int   c = d >> 6;
      int   f = d & 63;
      if (c >= 15) begin
         it.lo = 15; it.hi = 15; it.sum = 15 * nper;
      end else begin
         it.lo  = c;
         it.hi  = (f == 0) ? c : c + 1;
         it.sum = (nper == 64) ? 64 * c + f : c * nper;
      end
      it.nper = nper;
      it.tag  = tag;
      q.push_back(it);
      n_push++;
      wait (n_done == n_push);
   endtask

   // monitor: pops expected items and compares measured periods
   initial begin
      forever begin
         exp_t it;
         int   total;
         wait (q.size() > 0);
         it    = q.pop_front();
         total = 0;
         for (int p = 0; p < it.nper; p++) begin
            int s, aw, bo, cw, dof, gap;
            measure_period(-1, s, aw, bo, cw, dof, gap);
            chk(s >= it.lo && s <= it.hi, {it.tag, " R5 shift"}, s, it.lo);
            if (p > 0) chk(gap == 1, "R2 period 32", gap, 1);
            chk(aw == 14, "R2 sw_a width", aw, 14);
            chk(bo == 16, "R3 sw_b offset", bo, 16);
            chk(cw == 14, "R4 sw_c width", cw, 14);
            if (it.lo == it.hi) chk(dof == 16, "R4 sw_d offset", dof, 16);
            total += s;
         end
         chk(total == it.sum, {it.tag, " shift sum"}, total, it.sum);
         n_done++;
      end
   end

   // driver
   initial begin
      int k, s, aw, bo, cw, dof, gap;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk({sw_a, sw_b, sw_c, sw_d} == 4'b0, "R1 outputs in reset",
             int'({sw_a, sw_b, sw_c, sw_d}), 0);
      end
      rst_n = 1'b1;
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!(sw_a && !sa_p) && k < 100);
      chk(k == 3, "R1 first sw_a rise", k, 3);

      push_item(0, 8, "R7 zero duty");
      apply(5 * 64);
      push_item(5 * 64, 4, "R5 coarse 5");

      // R9: command injected just after sw_a rises
      measure_period(12 * 64, s, aw, bo, cw, dof, gap);
      chk(s == 5, "R9 current period unchanged", s, 5);
      measure_period(-1, s, aw, bo, cw, dof, gap);
      chk(s == 12, "R9 next period updated", s, 12);

      // R10: duty moves without strobe
      @(negedge clk);
      duty = 11'd0;
      for (int i = 0; i < 3; i++) begin
         measure_period(-1, s, aw, bo, cw, dof, gap);
         chk(s == 12, "R10 no strobe ignored", s, 12);
      end

      apply(7 * 64 + 21);
      push_item(7 * 64 + 21, 64, "R6 dither 469");
      apply(3 * 64 + 63);
      push_item(3 * 64 + 63, 64, "R6 dither 255");
      apply(14 * 64 + 1);
      push_item(14 * 64 + 1, 64, "R6 dither 897");
      apply(15 * 64 + 40);
      push_item(15 * 64 + 40, 64, "R8 carry saturation");
      apply(2047);
      push_item(2047, 8, "R8 full scale");
      apply(0);
      push_item(0, 4, "R7 back to zero");

      chk(ovl_ab == 0, "R3 sw_a/sw_b overlap", ovl_ab, 0);
      chk(ovl_cd == 0, "R4 sw_c/sw_d overlap", ovl_cd, 0);
      report();
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      report();
   end

endmodule